// File: doc/BRIEF.md
# Parallel Flash Command-Sequence Decoder

This block sits behind the host write port of a 16-bit NOR-style flash controller. It watches every write the host makes (a valid flag with an address and a data word). It recognises the multi-cycle unlock-and-command sequences that select flash operations. When a sequence completes, it raises a one-cycle operation strobe with an operation code. The address and data of the final write are latched and presented alongside the strobe, so that the program/erase engine and the read-path mode logic downstream need no knowledge of the command protocol.

Most commands start with a two-write unlock handshake: 0xAA to address 0x555, then 0x55 to 0x2AA. Erase commands need a second unlock before the final cycle, which picks either chip or sector erase. A few commands take a single write and need no unlock: reset to read-array, query, suspend and resume. Any write that breaks a sequence sends the decoder into a sticky error state. Only the reset command leaves that state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, op_valid and seq_error are low. After reset the decoder is idle and waiting for the first write of a sequence.
- R2: From idle, a single write starts one of four commands. Data 0xF0 at any address gives read-array. Data 0x98 at decode address 0x055 gives query. Data 0xB0 at any address gives suspend. Data 0x30 at any address gives resume.
- R3: The unlock pair is 0xAA at 0x555, then 0x55 at 0x2AA. Neither write produces a strobe.
- R4: After unlock, 0xA0 at 0x555 produces no strobe. The next write, whatever its value, gives program, carrying that write's address and data.
- R5: After unlock, 0x90 at 0x555 gives autoselect. A following write of 0x00 at any address gives secure-region exit.
- R6: After unlock, 0x88 at 0x555 gives secure-region entry.
- R7: Erase is unlock, then 0x80 at 0x555, then a second unlock, then a final write. The final write is 0x10 at 0x555 for chip erase, or 0x30 at any address for sector erase, with that address latched.
- R8: Matching uses only data bits 7:0 and address bits 10:0. Higher bits have no effect on which command is decoded.
- R9: Any write that fits no expected step sets seq_error, which stays high. While it is high, every write other than 0xF0 gives no strobe.
- R10: Data 0xF0 gives read-array and returns the decoder to idle in every state, including the error state, where it also clears seq_error. The one exception is the program-data cycle, where 0xF0 is taken as program data.
- R11: Each recognised command gives exactly one strobe, on the cycle after its final write, with op_addr and op_data equal to that write's address and data. Codes: read-array 1, autoselect 2, query 3, program 4, chip erase 5, sector erase 6, suspend 7, resume 8, secure entry 9, secure exit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write cycle this clock |
| wr_addr | input | ADDR_W | Write address (word) |
| wr_data | input | DATA_W | Write data |
| op_valid | output | 1 | One-cycle operation strobe |
| op_code | output | 4 | Operation code (see R11) |
| op_addr | output | ADDR_W | Address of the final write of the command |
| op_data | output | DATA_W | Data of the final write of the command |
| seq_error | output | 1 | Sticky sequence-error flag |

## Verification
The assertions assume that the host presents at most one write per clock. They also assume that address and data are meaningful only while wr_valid is high, and that reset is held long enough to clear the state register. The stimulus drives writes as single-cycle pulses set up half a period before the edge, with idle cycles between groups. It sweeps every low data byte as both the first and the third command cycle, mixing changing high address and data bits into each write. After every sweep step it returns the decoder to idle with a reset command, so each case starts from a known state.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_READ     = 4'd1,
    OP_AUTOSEL  = 4'd2,
    OP_QUERY    = 4'd3,
    OP_PROGRAM  = 4'd4,
    OP_CHIP_ER  = 4'd5,
    OP_SECT_ER  = 4'd6,
    OP_SUSPEND  = 4'd7,
    OP_RESUME   = 4'd8,
    OP_SEC_IN   = 4'd9,
    OP_SEC_OUT  = 4'd10
  } fcd_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ER1, S_ER2, S_ER3, S_ASEL, S_ERR
  } fcd_state_e;

  // One flag per recognised address/data pattern of the current write
  typedef struct packed {
    logic unl1;   // 0xAA @ 0x555
    logic unl2;   // 0x55 @ 0x2AA
    logic a0;     // 0xA0 @ 0x555
    logic d90;    // 0x90 @ 0x555
    logic d80;    // 0x80 @ 0x555
    logic d88;    // 0x88 @ 0x555
    logic d10;    // 0x10 @ 0x555
    logic d30;    // 0x30 anywhere
    logic f0;     // 0xF0 anywhere
    logic qry;    // 0x98 @ 0x055
    logic b0;     // 0xB0 anywhere
    logic d00;    // 0x00 anywhere
  } fcd_hit_t;

  // Compare the low w bits of two values
  function automatic logic low_eq(input logic [31:0] val, input logic [31:0] pat,
                                  input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? '1 : ((32'd1 << w) - 32'd1);
    return ((val ^ pat) & mask) == 32'd0;
  endfunction

endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int DEC_W  = 11,
  parameter int CMD_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output fcd_hit_t          hit
);
  logic [31:0] a32, d32;
  logic at555, at2aa, at055;

  assign a32 = 32'(addr);
  assign d32 = 32'(data);

  assign at555 = low_eq(a32, 32'h555, DEC_W);
  assign at2aa = low_eq(a32, 32'h2AA, DEC_W);
  assign at055 = low_eq(a32, 32'h055, DEC_W);

  always_comb begin
    hit.unl1 = at555 && low_eq(d32, 32'hAA, CMD_W);
    hit.unl2 = at2aa && low_eq(d32, 32'h55, CMD_W);
    hit.a0   = at555 && low_eq(d32, 32'hA0, CMD_W);
    hit.d90  = at555 && low_eq(d32, 32'h90, CMD_W);
    hit.d80  = at555 && low_eq(d32, 32'h80, CMD_W);
    hit.d88  = at555 && low_eq(d32, 32'h88, CMD_W);
    hit.d10  = at555 && low_eq(d32, 32'h10, CMD_W);
    hit.d30  = low_eq(d32, 32'h30, CMD_W);
    hit.f0   = low_eq(d32, 32'hF0, CMD_W);
    hit.qry  = at055 && low_eq(d32, 32'h98, CMD_W);
    hit.b0   = low_eq(d32, 32'hB0, CMD_W);
    hit.d00  = low_eq(d32, 32'h00, CMD_W);
  end
endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  fcd_hit_t   hit,
  output fcd_state_e state,
  output logic       fire,
  output fcd_op_e    fire_op
);
  fcd_state_e nxt;

  always_comb begin
    nxt     = state;
    fire    = 1'b0;
    fire_op = OP_NONE;
    if (wr_valid) begin
      if (state == S_PROG) begin
        fire = 1'b1; fire_op = OP_PROGRAM; nxt = S_IDLE;
      end else if (hit.f0) begin
        fire = 1'b1; fire_op = OP_READ; nxt = S_IDLE;
      end else begin
        nxt = S_ERR;
        case (state)
          S_IDLE: begin
            if (hit.qry)       begin fire = 1'b1; fire_op = OP_QUERY;   nxt = S_IDLE; end
            else if (hit.b0)   begin fire = 1'b1; fire_op = OP_SUSPEND; nxt = S_IDLE; end
            else if (hit.d30)  begin fire = 1'b1; fire_op = OP_RESUME;  nxt = S_IDLE; end
            else if (hit.unl1) nxt = S_UNL1;
          end
          S_UNL1: if (hit.unl2) nxt = S_UNL2;
          S_UNL2: begin
            if (hit.a0)        nxt = S_PROG;
            else if (hit.d80)  nxt = S_ER1;
            else if (hit.d90)  begin fire = 1'b1; fire_op = OP_AUTOSEL; nxt = S_ASEL; end
            else if (hit.d88)  begin fire = 1'b1; fire_op = OP_SEC_IN;  nxt = S_IDLE; end
          end
          S_ER1: if (hit.unl1) nxt = S_ER2;
          S_ER2: if (hit.unl2) nxt = S_ER3;
          S_ER3: begin
            if (hit.d10)       begin fire = 1'b1; fire_op = OP_CHIP_ER; nxt = S_IDLE; end
            else if (hit.d30)  begin fire = 1'b1; fire_op = OP_SECT_ER; nxt = S_IDLE; end
          end
          S_ASEL: begin
            if (hit.d00)       begin fire = 1'b1; fire_op = OP_SEC_OUT; nxt = S_IDLE; end
            else if (hit.unl1) nxt = S_UNL1;
          end
          default: nxt = S_ERR;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/fcd_out.sv
module fcd_out
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  fcd_op_e           fire_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              op_valid,
  output logic [3:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_code  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_valid <= fire;
      if (fire) begin
        op_code <= fire_op;
        op_addr <= addr;
        op_data <= data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              op_valid,
  output logic [3:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              seq_error
);
  localparam int DEC_W = 11;
  localparam int CMD_W = 8;

  fcd_hit_t   hit;
  fcd_state_e state;
  logic       fire;
  fcd_op_e    fire_op;
  logic       in_prog;

  fcd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEC_W(DEC_W), .CMD_W(CMD_W)) match_i (
    .addr(wr_addr), .data(wr_data), .hit(hit)
  );

  fcd_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .hit(hit),
    .state(state), .fire(fire), .fire_op(fire_op)
  );

  fcd_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_op(fire_op),
    .addr(wr_addr), .data(wr_data),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_data(op_data)
  );

  assign in_prog   = (state == S_PROG);
  assign seq_error = (state == S_ERR);
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [ADDR_W-1:0] op_addr,
  input logic [DATA_W-1:0] op_data,
  input logic              seq_error,
  input logic              in_prog
);
  logic is_f0;
  assign is_f0 = wr_valid && (wr_data[7:0] == 8'hF0);

  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(wr_valid)); // R11
  AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !op_valid); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_error && !is_f0) |=> seq_error); // R9
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_error && wr_valid && !is_f0) |=> !op_valid); // R9
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_error && is_f0) |=> (!seq_error && op_valid && op_code == OP_READ)); // R10
  AST_PROG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && wr_valid) |=> (op_valid && op_code == OP_PROGRAM &&
      op_addr == $past(wr_addr) && op_data == $past(wr_data))); // R4
  AST_STROBE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !seq_error); // R9
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
  .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_data(op_data),
  .seq_error(seq_error), .in_prog(in_prog)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          op_valid;
  logic [3:0]    op_code;
  logic [AW-1:0] op_addr;
  logic [15:0]   op_data;
  logic          seq_error;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_data(op_data),
    .seq_error(seq_error)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one write cycle; outputs sampled at the following falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic exp_op(input string req, input logic [3:0] op,
                        input logic [AW-1:0] a, input logic [15:0] d);
    chk(op_valid == 1'b1, req, "op_valid", 32'(op_valid), 32'd1);
    chk(op_code == op,    req, "op_code",  32'(op_code),  32'(op));
    chk(op_addr == a,     req, "op_addr",  32'(op_addr),  32'(a));
    chk(op_data == d,     req, "op_data",  32'(op_data),  32'(d));
    chk(seq_error == 1'b0, req, "seq_error", 32'(seq_error), 32'd0);
  endtask

  task automatic exp_none(input string req, input bit err);
    chk(op_valid == 1'b0, req, "no strobe", 32'(op_valid), 32'd0);
    chk(seq_error == err, req, "seq_error", 32'(seq_error), 32'(err));
  endtask

  task automatic unlock(input logic [AW-1:0] hi, input logic [7:0] dh, input string req);
    wr(hi | AW'(12'h555), {dh, 8'hAA}); exp_none(req, 1'b0);
    wr(hi | AW'(12'h2AA), {dh, 8'h55}); exp_none(req, 1'b0);
  endtask

  task automatic clear(input logic [AW-1:0] a);
    wr(a, 16'h00F0); exp_op("R10", 4'd1, a, 16'h00F0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run hung actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] hi;
    logic [AW-1:0] sa;
    logic [7:0]    dh;
    // R1 reset state
    repeat (3) @(negedge clk);
    exp_none("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    exp_none("R1", 1'b0);

    // R2/R9: sweep every low byte as a first write at two decode addresses
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 256; d++) begin
        logic [AW-1:0] a;
        logic [15:0] wd;
        int eop;
        hi = AW'((d * 37 + s) & 511) << 11;
        a  = hi | (s == 0 ? AW'(12'h055) : AW'(12'h555));
        wd = {8'(d ^ 8'h5A), 8'(d)};
        eop = (d == 8'hF0) ? 1 : (d == 8'h98 && s == 0) ? 3 : (d == 8'hB0) ? 7 :
              (d == 8'h30) ? 8 : 0;
        wr(a, wd);
        if (eop != 0) exp_op("R2", 4'(eop), a, wd);
        else if (d == 8'hAA && s == 1) begin exp_none("R3", 1'b0); clear(a); end
        else begin
          exp_none("R9", 1'b1);
          wr(a, 16'h00B0); exp_none("R9", 1'b1);
          clear(a);
        end
      end
    end

    // R3-R6/R8/R9: sweep every low byte as the third cycle after unlock
    for (int d = 0; d < 256; d++) begin
      logic [15:0] wd;
      hi = AW'((d * 53) & 511) << 11;
      dh = 8'(d * 7 + 1);
      wd = {dh, 8'(d)};
      unlock(hi, dh, "R8");
      wr(hi | AW'(12'h555), wd);
      if (d == 8'hA0) begin
        exp_none("R4", 1'b0);
        wr(AW'(20'hABCDE) ^ hi, 16'h1234 ^ 16'(d));
        exp_op("R4", 4'd4, AW'(20'hABCDE) ^ hi, 16'h1234 ^ 16'(d));
      end else if (d == 8'h90) begin
        exp_op("R5", 4'd2, hi | AW'(12'h555), wd);
        wr(AW'(20'h12345), 16'hFF00);
        exp_op("R5", 4'd10, AW'(20'h12345), 16'hFF00);
      end else if (d == 8'h88) begin
        exp_op("R6", 4'd9, hi | AW'(12'h555), wd);
      end else if (d == 8'hF0) begin
        exp_op("R10", 4'd1, hi | AW'(12'h555), wd);
      end else if (d == 8'h80) begin
        exp_none("R7", 1'b0);
        clear(AW'(20'h00777));
      end else begin
        exp_none("R9", 1'b1);
        clear(AW'(20'h00001));
      end
      @(negedge clk);
      exp_none("R11", 1'b0);
    end

    // R7 chip and sector erase, with high bits set
    hi = AW'(20'hF8000);
    unlock(hi, 8'hC3, "R7");
    wr(hi | AW'(12'h555), 16'hC380); exp_none("R7", 1'b0);
    unlock(hi, 8'h3C, "R7");
    wr(hi | AW'(12'h555), 16'h7710); exp_op("R7", 4'd5, hi | AW'(12'h555), 16'h7710);
    @(negedge clk); exp_none("R11", 1'b0);

    for (int k = 0; k < 8; k++) begin
      sa = AW'(k * 20'h1A3C5 + 20'h00123);
      unlock('0, 8'h00, "R7");
      wr(AW'(12'h555), 16'h0080); exp_none("R7", 1'b0);
      unlock('0, 8'h00, "R7");
      wr(sa, 16'h0030); exp_op("R7", 4'd6, sa, 16'h0030);
    end

    // R7/R9: chip-erase code at the wrong address is an error
    unlock('0, 8'h00, "R7");
    wr(AW'(12'h555), 16'h0080); exp_none("R7", 1'b0);
    unlock('0, 8'h00, "R7");
    wr(AW'(12'h554), 16'h0010); exp_none("R9", 1'b1);
    wr(AW'(12'h555), 16'h00AA); exp_none("R9", 1'b1);
    clear(AW'(12'h2AA));

    // R10: reset mid-sequence, and 0xF0 as program data
    unlock('0, 8'h00, "R10");
    wr(AW'(12'h555), 16'h0080); exp_none("R10", 1'b0);
    wr(AW'(12'h555), 16'h00AA); exp_none("R10", 1'b0);
    clear(AW'(12'h321));
    unlock('0, 8'h00, "R10");
    wr(AW'(12'h555), 16'h00A0); exp_none("R4", 1'b0);
    wr(AW'(20'h54321), 16'h00F0); exp_op("R10", 4'd4, AW'(20'h54321), 16'h00F0);
    @(negedge clk); exp_none("R11", 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule